// File: doc/BRIEF.md
# Cascadable Serial Position Shift Register

This block turns a parallel absolute-position word into a serial bit stream on one output pin. A host drives two slow inputs: a level control that holds the block in capture mode or releases it into shift mode, and a shift clock. While capture is selected, the register copies the position word on every system clock and the output shows the top bit of the word. When capture is released, the register keeps the word it holds. From then on, every rising edge of the shift clock moves the next lower bit onto the output, so the most significant bit leaves first.

A serial input fills the vacated bottom position on each shift. Connecting one block's output to another block's serial input therefore lets a single reader pull several words back to back. Feeding the output back into the input gives ring operation. A reader may stop after any number of clocks and gets the top bits of the word only.

The control, the shift clock and the serial input are brought into the system clock domain through synchronizer chains of equal depth, and the shift clock is edge-detected there. The system clock must run at least four times faster than the shift clock.

Top module: `serial_pos_sreg`

## Requirements
- R1: While reset is high, and on the first clock after it, `ser_out` is 0 and the internal word is cleared.
- R2: While `load_hold` is high (capture mode), the word is recaptured from `pos_word` on every clock. `ser_out` then equals bit WIDTH-1 of the captured word, and the output follows a change of the word within SYNC_STAGES+2 clocks.
- R3: Once `load_hold` is low (shift mode), changes of `pos_word` have no effect on the frame being read. The word captured last before the low level reached the core is the word that is shifted.
- R4: In shift mode, each rising edge of `shift_clk` advances the register by exactly one bit, the most significant bit first. `ser_out` shows the new bit SYNC_STAGES+1 system clocks after the edge.
- R5: On each shift, the value of `ser_in` (sampled through the same synchronizer depth) enters bit 0. With block A's `ser_in` tied to block B's `ser_out`, 32 shifts deliver A's word and then B's word, each MSB first.
- R6: After WIDTH shifts with no new capture, `ser_out` presents the bits taken from `ser_in`, in the order in which they arrived.
- R7: A read may end after fewer than WIDTH clocks, for example 12. It yields the top bits of the word in order, and raising `load_hold` again restores the MSB of the current word on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_word | input | WIDTH | Parallel position word to be serialized |
| load_hold | input | 1 | 1 = capture mode, 0 = shift mode (asynchronous) |
| shift_clk | input | 1 | Reader's shift clock; its rising edge shifts (asynchronous) |
| ser_in | input | 1 | Serial input into bit 0, used for chaining or ring operation |
| ser_out | output | 1 | Serial output, the register's top bit |

## Verification
Two instances are chained and given words whose bit patterns differ in every nibble. A 32-bit read therefore separates a correct MSB-first order from a reversed order, a dropped bit, a doubled bit or a swapped word. A further 16 clocks carry a known pattern from the far serial input. This shows whether bits pass through both registers in arrival order rather than being lost or replaced by zeros. During the read the position word is changed, which exposes a register that does not freeze its capture. A 12-clock read followed by a new capture checks that a truncated frame yields the top bits and that the output returns to the fresh MSB. A cycle-accurate reference model follows both outputs on every clock, so it also catches latency errors.

// File: rtl/pos_sreg_pkg.sv
package pos_sreg_pkg;
  // Default frame length and synchronizer depth.
  localparam int unsigned DEF_WIDTH       = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Operating mode seen by the shift core after synchronization.
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2
  } core_mode_e;
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/psr_edge_det.sv
module psr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level;
  end

  assign rise = level & ~level_d;
endmodule

// File: rtl/psr_shift_core.sv
module psr_shift_core
  import pos_sreg_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] word
);
  core_mode_e mode;

  always_comb begin
    if (load_en)       mode = MODE_LOAD;
    else if (shift_en) mode = MODE_SHIFT;
    else               mode = MODE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else begin
      unique case (mode)
        MODE_LOAD:  word <= par_in;
        MODE_SHIFT: word <= {word[WIDTH-2:0], bit_in};
        default:    word <= word;
      endcase
    end
  end
endmodule

// File: rtl/serial_pos_sreg.sv
module serial_pos_sreg
  import pos_sreg_pkg::*;
#(
  parameter int unsigned WIDTH       = DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pos_word,
  input  logic             load_hold,
  input  logic             shift_clk,
  input  logic             ser_in,
  output logic             ser_out
);
  localparam int unsigned N_SYNC = 3;

  logic [N_SYNC-1:0] async_in;
  logic [N_SYNC-1:0] synced;
  logic              ld_sync;
  logic              sclk_sync;
  logic              sin_sync;
  logic              shift_rise;
  logic [WIDTH-1:0]  sreg;

  assign async_in = {ser_in, shift_clk, load_hold};

  // Equal depth on all three inputs keeps the serial data aligned with its clock.
  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    psr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (async_in[g]),
      .q   (synced[g])
    );
  end

  assign ld_sync   = synced[0];
  assign sclk_sync = synced[1];
  assign sin_sync  = synced[2];

  psr_edge_det u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sclk_sync),
    .rise  (shift_rise)
  );

  psr_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load_en  (ld_sync),
    .shift_en (shift_rise),
    .bit_in   (sin_sync),
    .par_in   (pos_word),
    .word     (sreg)
  );

  assign ser_out = sreg[WIDTH-1];
endmodule

// File: rtl/pos_sreg_checker.sv
module pos_sreg_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] pos_word,
  input logic             ld_s,
  input logic             rise,
  input logic             sin_s,
  input logic [WIDTH-1:0] sreg,
  input logic             ser_out
);
  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_clear_R1: assert (ser_out == 1'b0 && sreg == '0)
        else $error("R1: output not cleared after reset");
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ld_s |=> (ser_out == $past(pos_word[WIDTH-1])));

  assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && !rise) |=> $stable(sreg));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && rise) |=> (ser_out == $past(sreg[WIDTH-2])));

  assert_single_edge_R4: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  assert_serial_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && rise) |=> (sreg[0] == $past(sin_s)));
endmodule

bind serial_pos_sreg pos_sreg_checker #(.WIDTH(WIDTH)) u_pos_sreg_chk (
  .clk      (clk),
  .rst      (rst),
  .pos_word (pos_word),
  .ld_s     (ld_sync),
  .rise     (shift_rise),
  .sin_s    (sin_sync),
  .sreg     (sreg),
  .ser_out  (ser_out)
);

// File: tb/serial_pos_sreg_bench.sv
`timescale 1ns/1ps
module serial_pos_sreg_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pos_a = '0;
  logic [W-1:0] pos_b = '0;
  logic         ld = 1'b1;
  logic         sclk = 1'b0;
  logic         ext_sin = 1'b0;
  logic         sout_a, sout_b;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // Instance A is next to the reader; B feeds A's serial input.
  serial_pos_sreg #(.WIDTH(W), .SYNC_STAGES(2)) u_serial_pos_sreg (
    .clk(clk), .rst(rst), .pos_word(pos_a), .load_hold(ld),
    .shift_clk(sclk), .ser_in(sout_b), .ser_out(sout_a));

  serial_pos_sreg #(.WIDTH(W), .SYNC_STAGES(2)) u_serial_pos_sreg_b (
    .clk(clk), .rst(rst), .pos_word(pos_b), .load_hold(ld),
    .shift_clk(sclk), .ser_in(ext_sin), .ser_out(sout_b));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: delay lines as queues, words as bit queues.
  bit m_ld_q[$], m_sc_q[$], m_ia_q[$], m_ib_q[$];
  bit m_sc_prev;
  bit m_a[$], m_b[$];

  function automatic void m_clear();
    m_ld_q = '{0, 0}; m_sc_q = '{0, 0}; m_ia_q = '{0, 0}; m_ib_q = '{0, 0};
    m_sc_prev = 0;
    m_a.delete(); m_b.delete();
    for (int i = 0; i < W; i++) begin m_a.push_back(0); m_b.push_back(0); end
  endfunction

  initial m_clear();

  always @(posedge clk) begin
    if (rst) begin
      m_clear();
    end else begin
      bit l_s, c_s, a_s, b_s, rise_m, b_msb;
      l_s = m_ld_q[0]; c_s = m_sc_q[0]; a_s = m_ia_q[0]; b_s = m_ib_q[0];
      rise_m = c_s && !m_sc_prev;
      b_msb = m_b[0];
      if (l_s) begin
        m_a.delete(); m_b.delete();
        for (int i = W - 1; i >= 0; i--) begin
          m_a.push_back(pos_a[i]); m_b.push_back(pos_b[i]);
        end
      end else if (rise_m) begin
        void'(m_a.pop_front()); m_a.push_back(a_s);
        void'(m_b.pop_front()); m_b.push_back(b_s);
      end
      m_sc_prev = c_s;
      void'(m_ld_q.pop_front()); m_ld_q.push_back(ld);
      void'(m_sc_q.pop_front()); m_sc_q.push_back(sclk);
      void'(m_ia_q.pop_front()); m_ia_q.push_back(b_msb);
      void'(m_ib_q.pop_front()); m_ib_q.push_back(ext_sin);
    end
  end

  // Per-cycle comparison of both outputs against the model (R4 timing, R2 tracking).
  always @(negedge clk) begin
    if (!rst) begin
      check("R4 model A", sout_a, m_a[0]);
      check("R5 model B", sout_b, m_b[0]);
    end
  end

  // Reads n bits, sampling late in the low phase, and drives ext_sin from pat.
  logic rd_bits[$];
  task automatic read_bits(input int n, input logic [W-1:0] pat, input bit use_pat);
    rd_bits.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_bits.push_back(sout_a);
      ext_sin = use_pat ? pat[W-1-(i % W)] : 1'b0;
      @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] wa, wb, pat;
    repeat (4) @(negedge clk);
    check("R1 reset A", sout_a, 1'b0);
    check("R1 reset B", sout_b, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", sout_a, 1'b0);

    // R2: capture mode tracks the word.
    pos_a = 16'h8001;
    repeat (4) @(negedge clk);
    check("R2 msb one", sout_a, 1'b1);
    pos_a = 16'h7FFE;
    repeat (4) @(negedge clk);
    check("R2 msb zero", sout_a, 1'b0);

    // R5/R3/R6: chained 48-bit read.
    wa = 16'hA5C3; wb = 16'h3C96; pat = 16'hB00F;
    pos_a = wa; pos_b = wb;
    repeat (4) @(negedge clk);
    ld = 1'b0;
    repeat (6) @(negedge clk);
    pos_a = ~wa; pos_b = ~wb;   // R3: must not disturb the frozen frame
    read_bits(48, pat, 1'b1);
    for (int i = 0; i < W; i++) check("R5 word A", rd_bits[i], wa[W-1-i]);
    for (int i = 0; i < W; i++) check("R5 word B", rd_bits[W+i], wb[W-1-i]);
    for (int i = 0; i < W; i++) check("R6 arrival order", rd_bits[2*W+i], pat[W-1-i]);
    check("R3 frozen msb", rd_bits[0], 1'b1);

    // R7: truncated 12-clock read, then a new capture.
    ld = 1'b1;
    pos_a = 16'h5E71;
    repeat (6) @(negedge clk);
    check("R2 recapture", sout_a, 1'b0);
    ld = 1'b0;
    repeat (6) @(negedge clk);
    read_bits(12, '0, 1'b0);
    for (int i = 0; i < 12; i++) check("R7 truncated", rd_bits[i], pos_a[W-1-i]);
    pos_a = 16'hC000;
    ld = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 reload msb", sout_a, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule